// File: doc/BRIEF.md
# Extended wait-state arbiter

This block decides, cycle by cycle, whether the strobe phase of an asynchronous external memory access must be stretched. Four external ready/wait pins, numbered 2 to 5, enter through a two-stage synchronizer. Each of the four chip selects, also numbered 2 to 5, is steered to one of those pins through a programmable 2-bit map. Each pin has its own polarity bit that says which level means "wait".

The access sequencer supplies the active chip select, a strobe-phase indication and one extended-wait enable bit per chip select. In return it receives a hold signal. A programmable ceiling bounds the number of wait cycles inserted in one access. When the ceiling is reached, the hold is dropped whatever the pin is doing, and a one-cycle timeout flag is raised. All settings live in one 32-bit configuration word, which is written through a simple write port and can be read back.

Top module: `ext_wait_arbiter`

## Requirements
- R1: After reset the configuration word reads 0xF0E40080. This means all four polarity bits are 1, each chip select maps to the pin with its own number, and the ceiling is 0x80.
- R2: Bits 27:24 and 15:8 of the configuration word always read 0, and writing them has no effect. Writing 0xFFFFFFFF reads back 0xF0FF00FF.
- R3: Polarity bit 28+k belongs to pin k+2, with pin bit k of `wait_i`. A value of 1 holds while the pin is high, and a value of 0 holds while it is low.
- R4: The pin for chip select k+2 is chosen by field [17+2k:16+2k], where `cs_sel_i`=k. Code c selects pin c+2.
- R5: If the extended-wait enable bit `ew_en_i[cs_sel_i]` is clear, `stall_o` stays low whatever the wait pins do.
- R6: `stall_o` is never high while `strobe_i` is low.
- R7: A change on a wait pin reaches `stall_o` after exactly two rising clock edges.
- R8: With the wait condition held, `stall_o` is high for exactly N cycles of one access, where N is the ceiling in bits 7:0. In the first cycle after that, `stall_o` is low and `timeout_o` is high for that one cycle only.
- R9: The wait-cycle count is cleared while `strobe_i` is low, so every new access gets the full ceiling again.
- R10: A ceiling of 0 prevents any hold and any timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 32 | Configuration word write data |
| cfg_rdata_o | output | 32 | Configuration word read-back |
| cs_sel_i | input | 2 | Active chip select, code k means chip select k+2 |
| strobe_i | input | 1 | Access is in its strobe phase |
| ew_en_i | input | 4 | Extended-wait enable, bit k for chip select k+2 |
| wait_i | input | 4 | Wait pins, bit k is pin k+2 |
| stall_o | output | 1 | Hold the access sequencer in the strobe phase |
| timeout_o | output | 1 | One-cycle pulse when the wait ceiling is hit |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and an 8-bit ceiling. With these values the exact two-edge pin latency can be observed. Small ceilings such as 3 and 0 can be written, which lets the release point, the single timeout pulse and the zero-ceiling case be reached in a few cycles. A ceiling of 0xFF keeps the table-driven polarity and mapping vectors well away from the timeout.

// File: rtl/ewa_pkg.sv
package ewa_pkg;
  localparam int NPIN    = 4;
  localparam int NCS     = 4;
  localparam int SEL_W   = $clog2(NPIN);
  localparam int CS_W    = $clog2(NCS);
  localparam int CNT_W   = 8;
  localparam int WORD_W  = 32;
  localparam int POL_LSB = 28;
  localparam int MAP_LSB = 16;
  localparam logic [WORD_W-1:0] CFG_RST   = 32'hF0E4_0080;
  localparam logic [WORD_W-1:0] CFG_WMASK = 32'hF0FF_00FF;

  typedef struct packed {
    logic [NPIN-1:0]            pol;
    logic [NCS-1:0][SEL_W-1:0]  pin_map;
    logic [CNT_W-1:0]           max_cnt;
  } ewa_cfg_t;
endpackage

// File: rtl/ewa_cfg_reg.sv
module ewa_cfg_reg
  import ewa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output ewa_cfg_t          cfg_o
);
  logic [WORD_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RST;
    else if (we_i) cfg_q <= wdata_i & CFG_WMASK;
  end

  assign rdata_o       = cfg_q;
  assign cfg_o.pol     = cfg_q[POL_LSB +: NPIN];
  assign cfg_o.max_cnt = cfg_q[CNT_W-1:0];

  for (genvar k = 0; k < NCS; k++) begin : g_map
    assign cfg_o.pin_map[k] = cfg_q[MAP_LSB + SEL_W*k +: SEL_W];
  end

  // R2: reserved bits stay zero
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[27:24] == 4'h0) && (rdata_o[15:8] == 8'h00));
endmodule

// File: rtl/ewa_wait_sync.sv
module ewa_wait_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else begin
      stg_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/ewa_stall_ctrl.sv
module ewa_stall_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             req_i,
  input  logic [CNT_W-1:0] max_i,
  output logic             stall_o,
  output logic             timeout_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tmo_q;
  logic             last_wait;

  assign stall_o   = strobe_i & req_i & (cnt_q < max_i);
  assign last_wait = ({1'b0, cnt_q} + 1'b1) == {1'b0, max_i};
  assign timeout_o = tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      if (!strobe_i)    cnt_q <= '0;  // cleared between accesses
      else if (stall_o) cnt_q <= cnt_q + 1'b1;
      tmo_q <= stall_o & last_wait;
    end
  end

  a_r8_timeout_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
  a_r8_release_on_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !stall_o);
  a_r10_zero_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_i == '0) |-> (!stall_o && !timeout_o));
endmodule

// File: rtl/ext_wait_arbiter.sv
module ext_wait_arbiter
  import ewa_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  output logic [WORD_W-1:0] cfg_rdata_o,
  input  logic [CS_W-1:0]   cs_sel_i,
  input  logic              strobe_i,
  input  logic [NCS-1:0]    ew_en_i,
  input  logic [NPIN-1:0]   wait_i,
  output logic              stall_o,
  output logic              timeout_o
);
  ewa_cfg_t          cfg;
  logic [NPIN-1:0]   wait_s;
  logic [NPIN-1:0]   pin_act;
  logic [SEL_W-1:0]  sel_pin;
  logic              req;

  ewa_cfg_reg u_cfg (
    .clk_i, .rst_ni,
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg)
  );

  ewa_wait_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .async_i (wait_i),
    .sync_o  (wait_s)
  );

  for (genvar k = 0; k < NPIN; k++) begin : g_pol
    assign pin_act[k] = ~(wait_s[k] ^ cfg.pol[k]);
  end

  assign sel_pin = cfg.pin_map[cs_sel_i];
  assign req     = ew_en_i[cs_sel_i] & pin_act[sel_pin];

  ewa_stall_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni,
    .strobe_i  (strobe_i),
    .req_i     (req),
    .max_i     (cfg.max_cnt),
    .stall_o   (stall_o),
    .timeout_o (timeout_o)
  );

  a_r5_enable_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ew_en_i[cs_sel_i] |-> !stall_o);
  a_r6_strobe_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> strobe_i);
endmodule

// File: tb/ext_wait_arbiter_bench.sv
module ext_wait_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  cs_sel = '0;
  logic        strobe = 1'b0;
  logic [3:0]  ew_en = '0;
  logic [3:0]  wait_p = '0;
  logic        stall, timeout;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ext_wait_arbiter u_ext_wait_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .cs_sel_i(cs_sel), .strobe_i(strobe),
    .ew_en_i(ew_en), .wait_i(wait_p), .stall_o(stall), .timeout_o(timeout)
  );

  // {pol[3:0], map[7:0], cs[1:0], en[3:0], wait[3:0], exp_stall}
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {4'hF, 8'hE4, 2'd0, 4'hF, 4'b0001, 1'b1},  // R3 high-active pin2
    {4'hF, 8'hE4, 2'd0, 4'hF, 4'b0000, 1'b0},  // R3
    {4'hE, 8'hE4, 2'd0, 4'hF, 4'b0000, 1'b1},  // R3 low-active pin2
    {4'hE, 8'hE4, 2'd0, 4'hF, 4'b0001, 1'b0},  // R3
    {4'hF, 8'h24, 2'd3, 4'hF, 4'b0001, 1'b1},  // R4 cs5 -> pin2
    {4'hF, 8'h24, 2'd3, 4'hF, 4'b1000, 1'b0},  // R4 pin5 unused by cs5
    {4'hF, 8'hE4, 2'd0, 4'hE, 4'b0001, 1'b0},  // R5 enable clear
    {4'hF, 8'hE4, 2'd1, 4'hF, 4'b0010, 1'b1},  // R4 cs3 -> pin3
    {4'hB, 8'hE4, 2'd2, 4'hF, 4'b0000, 1'b1},  // R3 cs4 pin4 low-active
    {4'hB, 8'hE4, 2'd2, 4'hF, 4'b0100, 1'b0}   // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    int st_cnt, to_cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset word", cfg_rdata, 32'hF0E4_0080);
    chk("R1 reset stall", {31'd0, stall}, 32'd0);

    wr_cfg(32'hFFFF_FFFF);
    chk("R2 reserved masked", cfg_rdata, 32'hF0FF_00FF);
    wr_cfg(32'h0F00_FF00);
    chk("R2 reserved only write", cfg_rdata, 32'h0);

    // table-driven polarity / mapping / enable vectors
    for (int i = 0; i < NV; i++) begin
      wr_cfg({VEC[i][22:19], 4'h0, VEC[i][18:11], 8'h00, 8'hFF});
      cs_sel = VEC[i][10:9]; ew_en = VEC[i][8:5]; wait_p = VEC[i][4:1];
      repeat (3) @(negedge clk);
      strobe = 1'b1;
      #1;
      chk($sformatf("R3/R4/R5 vector %0d", i), {31'd0, stall}, {31'd0, VEC[i][0]});
      @(negedge clk);
      strobe = 1'b0;
    end

    // R6: active pin without strobe
    wr_cfg(32'hF0E4_00FF);
    cs_sel = 2'd0; ew_en = 4'hF; wait_p = 4'b0001;
    repeat (3) @(negedge clk);
    #1 chk("R6 no strobe", {31'd0, stall}, 32'd0);

    // R7: two-edge latency
    wait_p = 4'b0000;
    repeat (3) @(negedge clk);
    strobe = 1'b1;
    #1 chk("R7 idle pin", {31'd0, stall}, 32'd0);
    wait_p = 4'b0001;
    @(negedge clk); #1 chk("R7 after one edge", {31'd0, stall}, 32'd0);
    @(negedge clk); #1 chk("R7 after two edges", {31'd0, stall}, 32'd1);
    strobe = 1'b0;

    // R8: ceiling of 3
    wr_cfg(32'hF0E4_0003);
    repeat (2) @(negedge clk);
    strobe = 1'b1;
    st_cnt = 0; to_cnt = 0;
    for (int i = 0; i < 6; i++) begin
      #1;
      st_cnt += int'(stall); to_cnt += int'(timeout);
      if (i == 3) chk("R8 timeout with release", {30'd0, timeout, stall}, 32'd2);
      @(negedge clk);
    end
    chk("R8 stall cycles", st_cnt, 3);
    chk("R8 timeout pulses", to_cnt, 1);

    // R9: new access gets full budget
    strobe = 1'b0;
    @(negedge clk);
    strobe = 1'b1;
    st_cnt = 0;
    for (int i = 0; i < 6; i++) begin
      #1 st_cnt += int'(stall);
      @(negedge clk);
    end
    chk("R9 stall cycles after restart", st_cnt, 3);
    strobe = 1'b0;

    // R10: zero ceiling
    wr_cfg(32'hF0E4_0000);
    @(negedge clk);
    strobe = 1'b1;
    st_cnt = 0; to_cnt = 0;
    for (int i = 0; i < 4; i++) begin
      #1;
      st_cnt += int'(stall); to_cnt += int'(timeout);
      @(negedge clk);
    end
    chk("R10 zero ceiling stall", st_cnt, 0);
    chk("R10 zero ceiling timeout", to_cnt, 0);
    strobe = 1'b0;

    finish_run();
  end
endmodule